// File: doc/BRIEF.md
# Multi-Mode Fan Duty Controller

This block sets the PWM duty cycle of a single cooling fan. A two-bit mode field picks the control law. In speed mode a slow closed loop moves the duty one step per update period, so that the measured fan speed reaches a target held in the target register. In temperature mode the same loop runs, but the target register is rewritten on every clock from a small preset table, indexed by the band the current temperature falls in. In manual mode the duty comes straight from a software-written register.

The power-on mode comes from a strap input. A hold control can pin the duty at a programmable low level in any mode. A sticky fault flag is raised when the fan stays below its target at full duty for a programmable number of update periods. Software drives the block through a simple write port. Speed arrives as an 8-bit measurement, where a larger value means a faster fan, and temperature arrives as an 8-bit reading.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: Register 0 bits [1:0] select the mode, and mode_o shows it. Value 00 is speed mode and value 01 is temperature mode. Any value with bit 1 set is manual mode.
- R2: On the first clock after reset is released, the mode is loaded with {0, strap_i}. A high strap therefore starts the block in temperature mode.
- R3: In speed or temperature mode, with hold off, the duty is updated at each update tick, which comes once every UPD_DIV clocks. It rises by 1 when tach_i < expect_o and falls by 1 when tach_i > expect_o. It saturates at 0 and at 255, and it does not change when the two are equal.
- R4: In temperature mode, expect_o is reloaded on every clock from the selected preset, one cycle after its inputs. Writes to register 1 are then ignored. In the other modes a write to register 1 sets expect_o.
- R5: Thresholds T0..T3 are in registers 5..8 and presets P0..P4 are in registers 9..13. The preset chosen is P(k+1), where Tk is the highest threshold that temp_i strictly exceeds. If temp_i exceeds no threshold, P0 is chosen.
- R6: In manual mode with hold off, duty_o equals register 2 from the cycle after that register is written.
- R7: When register 0 bit 2 (hold) is set, duty_o equals register 3 in every mode. While hold is set, the loop duty is parked at that value, and the loop resumes from it once hold is cleared.
- R8: fault_o is set at the update tick where the count of consecutive ticks reaches register 4. A tick counts when the mode is speed or temperature, hold is off, the duty is 255 and tach_i < expect_o. When that condition fails, the count restarts. The flag is sticky. Writing register 0 with bit 3 set clears the flag and the count.
- R9: pwm_o is high while an 8-bit counter is below the duty. The counter advances once every PWM_DIV clocks, so a full period is 256*PWM_DIV clocks. pwm_o is registered.
- R10: After reset: duty_o = 0, fault_o = 0, pwm_o = 0, mode_o = 00, expect_o = 0x80, hold off, drop duty 0x40, fault time 8. The thresholds are 40, 55, 70 and 85, and the presets are 0x40, 0x70, 0xA0, 0xD0 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 1 | Power-on mode strap |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Register write data |
| tach_i | input | 8 | Measured fan speed |
| temp_i | input | 8 | Current temperature |
| pwm_o | output | 1 | PWM output to the fan |
| duty_o | output | 8 | Duty value in effect |
| expect_o | output | 8 | Speed target in effect |
| mode_o | output | 2 | Current mode |
| fault_o | output | 1 | Sticky fan fault flag |

## Verification
On every cycle the assertions check the following. In the automatic modes the duty moves by at most one step per clock. The duty is frozen while hold is set, and it is frozen in manual mode when no write occurs. The temperature target stays steady when its inputs are steady. The fault flag stays set until it is cleared, and it only rises after full duty. A zero duty gives a low output. The exact step timing, the band chosen for each temperature, the strap load, the fault delay and the PWM high time can only be shown by the bench scenarios, whose clock-by-clock reference model is compared against every output.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  typedef enum logic [1:0] {
    MODE_SPEED = 2'b00,
    MODE_TEMP  = 2'b01,
    MODE_MAN   = 2'b10
  } fan_mode_e;

  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_EXP   = 1;
  localparam int unsigned ADDR_MAN   = 2;
  localparam int unsigned ADDR_DROP  = 3;
  localparam int unsigned ADDR_FTIME = 4;
  localparam int unsigned ADDR_THR0  = 5;

  localparam int unsigned CTRL_HOLD_BIT = 2;
  localparam int unsigned CTRL_CLR_BIT  = 3;
endpackage

// File: rtl/fan_temp_sel.sv
module fan_temp_sel #(
  parameter int unsigned DW      = 8,
  parameter int unsigned NUM_THR = 4
) (
  input  logic [DW-1:0] temp_i,
  input  logic [DW-1:0] thr_i    [NUM_THR],
  input  logic [DW-1:0] preset_i [NUM_THR+1],
  output logic [DW-1:0] preset_o
);
  localparam int unsigned IW = $clog2(NUM_THR + 1);

  logic [IW-1:0] idx;

  always_comb begin
    idx = '0;
    for (int k = 0; k < NUM_THR; k++) begin
      if (temp_i > thr_i[k]) idx = IW'(k + 1);
    end
  end

  assign preset_o = preset_i[idx];
endmodule

// File: rtl/fan_duty_loop.sv
module fan_duty_loop #(
  parameter int unsigned DW      = 8,
  parameter int unsigned UPD_DIV = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          manual_i,
  input  logic          hold_i,
  input  logic [DW-1:0] drop_i,
  input  logic [DW-1:0] man_i,
  input  logic [DW-1:0] expect_i,
  input  logic [DW-1:0] tach_i,
  input  logic [DW-1:0] ftime_i,
  input  logic          fclr_i,
  output logic [DW-1:0] duty_o,
  output logic          fault_o
);
  localparam int unsigned UW = (UPD_DIV > 1) ? $clog2(UPD_DIV) : 1;
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};

  logic [UW-1:0] ucnt_q;
  logic          tick;
  logic [DW-1:0] duty_q;
  logic [DW-1:0] fcnt_q;
  logic [DW:0]   fcnt_inc;
  logic          stall;
  logic          fault_q;

  assign tick = (ucnt_q == UW'(UPD_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ucnt_q <= '0;
    else if (tick) ucnt_q <= '0;
    else           ucnt_q <= ucnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
    end else if (manual_i) begin
      duty_q <= man_i;                    // track for bumpless exit
    end else if (hold_i) begin
      duty_q <= drop_i;
    end else if (tick) begin
      if (tach_i < expect_i && duty_q != DMAX)     duty_q <= duty_q + 1'b1;
      else if (tach_i > expect_i && duty_q != '0)  duty_q <= duty_q - 1'b1;
    end
  end

  assign stall    = !manual_i && !hold_i && (duty_q == DMAX) && (tach_i < expect_i);
  assign fcnt_inc = {1'b0, fcnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q  <= '0;
      fault_q <= 1'b0;
    end else if (fclr_i) begin
      fcnt_q  <= '0;
      fault_q <= 1'b0;
    end else if (!stall) begin
      fcnt_q  <= '0;
    end else if (tick) begin
      fcnt_q <= fcnt_inc[DW] ? DMAX : fcnt_inc[DW-1:0];
      if (fcnt_inc >= {1'b0, ftime_i}) fault_q <= 1'b1;
    end
  end

  assign duty_o  = hold_i ? drop_i : (manual_i ? man_i : duty_q);
  assign fault_o = fault_q;
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int unsigned DW      = 8,
  parameter int unsigned PWM_DIV = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] duty_i,
  output logic          pwm_o
);
  localparam int unsigned PW = (PWM_DIV > 1) ? $clog2(PWM_DIV) : 1;

  logic [PW-1:0] pre_q;
  logic          ptick;
  logic [DW-1:0] pcnt_q;
  logic          pwm_q;

  assign ptick = (pre_q == PW'(PWM_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      pcnt_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      pre_q <= ptick ? '0 : pre_q + 1'b1;
      if (ptick) pcnt_q <= pcnt_q + 1'b1;
      pwm_q <= (pcnt_q < duty_i);
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pwm_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 4,
  parameter int unsigned NUM_THR  = 4,
  parameter int unsigned UPD_DIV  = 16,
  parameter int unsigned PWM_DIV  = 2,
  parameter int unsigned EXP_DEF  = 8'h80,
  parameter int unsigned DROP_DEF = 8'h40,
  parameter int unsigned FT_DEF   = 8,
  parameter int unsigned THR_BASE = 40,
  parameter int unsigned THR_STEP = 15,
  parameter int unsigned PRE_BASE = 8'h40,
  parameter int unsigned PRE_STEP = 8'h30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] tach_i,
  input  logic [DW-1:0] temp_i,
  output logic          pwm_o,
  output logic [DW-1:0] duty_o,
  output logic [DW-1:0] expect_o,
  output logic [1:0]    mode_o,
  output logic          fault_o
);
  localparam int unsigned ADDR_PRE0 = ADDR_THR0 + NUM_THR;
  localparam int unsigned DMAXI     = (1 << DW) - 1;

  logic          init_q;
  logic [1:0]    mode_q;
  logic          hold_q;
  logic [DW-1:0] exp_q, man_q, drop_q, ftime_q;
  logic [DW-1:0] thr_q [NUM_THR];
  logic [DW-1:0] pre_q [NUM_THR+1];
  logic [DW-1:0] preset_sel;
  logic          ctrl_wr, fclr;
  logic          temp_mode, manual;

  assign ctrl_wr   = wr_en_i && (wr_addr_i == AW'(ADDR_CTRL));
  assign fclr      = ctrl_wr && wr_data_i[CTRL_CLR_BIT];
  assign temp_mode = (mode_q == MODE_TEMP);
  assign manual    = mode_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      mode_q <= MODE_SPEED;
      hold_q <= 1'b0;
    end else begin
      init_q <= 1'b1;
      if (!init_q)      mode_q <= {1'b0, strap_i};
      else if (ctrl_wr) mode_q <= wr_data_i[1:0];
      if (ctrl_wr)      hold_q <= wr_data_i[CTRL_HOLD_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q   <= DW'(EXP_DEF);
      man_q   <= '0;
      drop_q  <= DW'(DROP_DEF);
      ftime_q <= DW'(FT_DEF);
    end else begin
      if (temp_mode)                                   exp_q   <= preset_sel;
      else if (wr_en_i && wr_addr_i == AW'(ADDR_EXP))  exp_q   <= wr_data_i;
      if (wr_en_i && wr_addr_i == AW'(ADDR_MAN))       man_q   <= wr_data_i;
      if (wr_en_i && wr_addr_i == AW'(ADDR_DROP))      drop_q  <= wr_data_i;
      if (wr_en_i && wr_addr_i == AW'(ADDR_FTIME))     ftime_q <= wr_data_i;
    end
  end

  for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
    localparam int unsigned TV = THR_BASE + k * THR_STEP;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          thr_q[k] <= DW'((TV > DMAXI) ? DMAXI : TV);
      else if (wr_en_i && wr_addr_i == AW'(ADDR_THR0 + k))  thr_q[k] <= wr_data_i;
    end
  end

  for (genvar k = 0; k <= NUM_THR; k++) begin : g_pre
    localparam int unsigned PV = PRE_BASE + k * PRE_STEP;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          pre_q[k] <= DW'((PV > DMAXI) ? DMAXI : PV);
      else if (wr_en_i && wr_addr_i == AW'(ADDR_PRE0 + k))  pre_q[k] <= wr_data_i;
    end
  end

  fan_temp_sel #(.DW(DW), .NUM_THR(NUM_THR)) u_sel (
    .temp_i   (temp_i),
    .thr_i    (thr_q),
    .preset_i (pre_q),
    .preset_o (preset_sel)
  );

  fan_duty_loop #(.DW(DW), .UPD_DIV(UPD_DIV)) u_loop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .manual_i (manual),
    .hold_i   (hold_q),
    .drop_i   (drop_q),
    .man_i    (man_q),
    .expect_i (exp_q),
    .tach_i   (tach_i),
    .ftime_i  (ftime_q),
    .fclr_i   (fclr),
    .duty_o   (duty_o),
    .fault_o  (fault_o)
  );

  fan_pwm_gen #(.DW(DW), .PWM_DIV(PWM_DIV)) u_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .duty_i (duty_o),
    .pwm_o  (pwm_o)
  );

  assign expect_o = exp_q;
  assign mode_o   = mode_q;
endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic [DW-1:0] temp_i,
  input logic          pwm_o,
  input logic [DW-1:0] duty_o,
  input logic [DW-1:0] expect_o,
  input logic [1:0]    mode_o,
  input logic          fault_o,
  input logic          hold_q,
  input logic [DW-1:0] drop_q
);
  AST_DUTY_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o[1] && !hold_q) ##1 (!mode_o[1] && !hold_q) |->
      (duty_o == $past(duty_o)) || (duty_o == $past(duty_o) + 1'b1) ||
      (duty_o == $past(duty_o) - 1'b1)); // R3

  AST_TEMP_EXPECT_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01 && !wr_en_i) ##1 (mode_o == 2'b01 && !wr_en_i && $stable(temp_i))
      |=> $stable(expect_o)); // R4

  AST_MANUAL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1] && !hold_q && !wr_en_i) ##1 (mode_o[1] && !hold_q) |-> $stable(duty_o)); // R6

  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q ##1 (hold_q && $stable(drop_q)) |-> $stable(duty_o)); // R7

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !(wr_en_i && wr_addr_i == '0 && wr_data_i[3])) |=> fault_o); // R8

  AST_FAULT_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> ($past(duty_o) == {DW{1'b1}})); // R8

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_o == '0) |=> !pwm_o); // R9
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .temp_i    (temp_i),
  .pwm_o     (pwm_o),
  .duty_o    (duty_o),
  .expect_o  (expect_o),
  .mode_o    (mode_o),
  .fault_o   (fault_o),
  .hold_q    (hold_q),
  .drop_q    (drop_q)
);

// File: tb/fan_pwm_ctrl_tb.sv
module fan_pwm_ctrl_tb;
  localparam int UPD = 16;
  localparam int PDV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] tach = 8'h80;
  logic [7:0] temp = 8'd20;
  logic       pwm;
  logic [7:0] duty, expv;
  logic [1:0] mode;
  logic       fault;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  fan_pwm_ctrl #(.UPD_DIV(UPD), .PWM_DIV(PDV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .tach_i(tach), .temp_i(temp),
    .pwm_o(pwm), .duty_o(duty), .expect_o(expv), .mode_o(mode), .fault_o(fault)
  );

  // reference model
  int m_mode, m_init, m_hold, m_exp, m_man, m_drop, m_ft, m_duty;
  int m_ucnt, m_fcnt, m_fault, m_pcnt, m_pwmc, m_pwm;
  int m_thr[4];
  int m_pre[5];

  function automatic int m_out_duty();
    if (m_hold != 0) return m_drop;
    if (m_mode >= 2) return m_man;
    return m_duty;
  endfunction

  function automatic int m_preset(int t);
    for (int k = 3; k >= 0; k--) if (t > m_thr[k]) return m_pre[k+1];
    return m_pre[0];
  endfunction

  task automatic m_reset();
    m_mode = 0; m_init = 0; m_hold = 0; m_exp = 'h80; m_man = 0; m_drop = 'h40;
    m_ft = 8; m_duty = 0; m_ucnt = 0; m_fcnt = 0; m_fault = 0; m_pcnt = 0;
    m_pwmc = 0; m_pwm = 0;
    m_thr = '{40, 55, 70, 85};
    m_pre = '{'h40, 'h70, 'hA0, 'hD0, 'hFF};
  endtask

  task automatic m_step();
    int a, d, tk, st, n_mode, n_hold, n_exp, n_duty, n_pwm;
    a = wr_en ? int'(wr_addr) : -1;
    d = int'(wr_data);
    tk = (m_ucnt == UPD - 1);
    n_mode = m_mode; n_hold = m_hold; n_exp = m_exp; n_duty = m_duty;
    if (m_init == 0) n_mode = int'(strap);
    else if (a == 0) n_mode = d & 3;
    if (a == 0) n_hold = (d >> 2) & 1;
    if (m_mode == 1) n_exp = m_preset(int'(temp));
    else if (a == 1) n_exp = d;
    if (m_mode >= 2) n_duty = m_man;
    else if (m_hold != 0) n_duty = m_drop;
    else if (tk != 0) begin
      if (int'(tach) < m_exp && m_duty < 255) n_duty = m_duty + 1;
      else if (int'(tach) > m_exp && m_duty > 0) n_duty = m_duty - 1;
    end
    st = (m_mode < 2) && (m_hold == 0) && (m_duty == 255) && (int'(tach) < m_exp);
    if (a == 0 && ((d >> 3) & 1) != 0) begin m_fcnt = 0; m_fault = 0; end
    else if (st == 0) m_fcnt = 0;
    else if (tk != 0) begin
      if (m_fcnt + 1 >= m_ft) m_fault = 1;
      m_fcnt = (m_fcnt + 1 > 255) ? 255 : m_fcnt + 1;
    end
    n_pwm = (m_pwmc < m_out_duty());
    if (m_pcnt == PDV - 1) begin m_pcnt = 0; m_pwmc = (m_pwmc + 1) % 256; end
    else m_pcnt++;
    m_ucnt = tk ? 0 : m_ucnt + 1;
    if (a == 2) m_man = d;
    if (a == 3) m_drop = d;
    if (a == 4) m_ft = d;
    if (a >= 5 && a <= 8) m_thr[a-5] = d;
    if (a >= 9 && a <= 13) m_pre[a-9] = d;
    m_mode = n_mode; m_hold = n_hold; m_exp = n_exp; m_duty = n_duty;
    m_pwm = n_pwm; m_init = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cmp_on && rst_n) begin
      check("R1 mode_o", int'(mode), m_mode);
      check("R4 expect_o", int'(expv), m_exp);
      check("R3 duty_o", int'(duty), m_out_duty());
      check("R8 fault_o", int'(fault), m_fault);
      check("R9 pwm_o", int'(pwm), m_pwm);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(bit s);
    cmp_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; strap = s;
    idle(2);
    // R10 reset values
    check("R10 duty", int'(duty), 0);
    check("R10 fault", int'(fault), 0);
    check("R10 pwm", int'(pwm), 0);
    check("R10 mode", int'(mode), 0);
    check("R10 expect", int'(expv), 'h80);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 strap mode", int'(mode), int'(s));
    cmp_on = 1'b1;
  endtask

  initial begin
    int hi;
    do_reset(1'b0);

    // R3 speed loop: up, down, steady
    tach = 8'h40;
    idle(20 * UPD + 2);
    check("R3 rise", int'(duty), 20);
    tach = 8'hA0;
    idle(5 * UPD);
    tach = 8'h80;
    idle(4 * UPD);
    check("R3 hold at equal", int'(duty), m_duty);

    // R8 fault at full duty
    wr(4, 3);
    tach = 8'h10;
    for (int i = 0; i < 6000 && duty != 8'hFF; i++) @(negedge clk);
    check("R3 saturate", int'(duty), 255);
    idle(4 * UPD + 4);
    check("R8 fault set", int'(fault), 1);
    wr(0, 'h08);
    check("R8 fault cleared", int'(fault), 0);
    tach = 8'h80;
    idle(6 * UPD);
    check("R8 stays clear", int'(fault), 0);

    // R1 / R6 manual mode
    wr(2, 'h33);
    wr(0, 'h03);
    check("R1 manual mode", int'(mode), 3);
    check("R6 manual duty", int'(duty), 'h33);
    wr(2, 'h5A);
    check("R6 manual rewrite", int'(duty), 'h5A);

    // R9 pwm high time
    wr(2, 'h80);
    idle(4);
    hi = 0;
    for (int i = 0; i < 256 * PDV; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
    check("R9 high count", hi, 'h80 * PDV);

    // R7 hold at drop duty
    wr(3, 'h25);
    wr(0, 'h06);
    check("R7 drop in manual", int'(duty), 'h25);
    wr(0, 'h04);
    tach = 8'h10;
    idle(8 * UPD);
    check("R7 drop held", int'(duty), 'h25);
    wr(0, 'h00);
    idle(3 * UPD);
    check("R7 resume from drop", int'(duty), m_out_duty());

    // R4 / R5 temperature table
    wr(0, 'h01);
    check("R1 temp mode", int'(mode), 1);
    temp = 8'd30; idle(2); check("R5 below all", int'(expv), 'h40);
    temp = 8'd40; idle(2); check("R5 equal T0", int'(expv), 'h40);
    temp = 8'd41; idle(2); check("R5 above T0", int'(expv), 'h70);
    temp = 8'd60; idle(2); check("R5 above T1", int'(expv), 'hA0);
    temp = 8'd85; idle(2); check("R5 equal T3", int'(expv), 'hD0);
    temp = 8'd200; idle(2); check("R5 top band", int'(expv), 'hFF);
    wr(1, 'h11);
    idle(1);
    check("R4 write ignored", int'(expv), 'hFF);
    wr(12, 'h99);
    temp = 8'd80; idle(2); check("R5 rewritten preset", int'(expv), 'h99);

    // R2 strap high
    do_reset(1'b1);
    idle(3);
    check("R2 strap temp mode", int'(mode), 1);
    wr(0, 'h00);
    wr(1, 'h22);
    idle(1);
    check("R4 write in speed", int'(expv), 'h22);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule